// File: doc/BRIEF.md
# Eight-Bit Float to Single-Precision Widening Converter

This block takes an 8-bit floating-point code and returns the IEEE single-precision word with exactly the same value. The narrow format has one sign bit, a 5-bit exponent biased by 16 and two stored fraction bits behind a hidden one. That gives three bits of precision, with gradual underflow below the smallest normal. The format has a single not-a-number code and no negative zero. Its two top codes are reserved for infinity, so the largest finite magnitude is 49152.

Every narrow value fits exactly in single precision, so the converter never rounds. A subnormal input is brought to normal form in the wide format: a leading-zero count on the fraction sets both the exponent and the remaining fraction bits. The block accepts one code per cycle with a valid flag. It returns the result one cycle later through a registered valid/data pair.

Top module: `f8_widen`

## Requirements
- R1: Input bit 7 is the sign, bits 6:2 are the exponent field E and bits 1:0 the fraction field F. For E in 1..31, other than the infinity codes, the output is (-1)^sign × (1 + F/4) × 2^(E-16) in single precision (0x40 gives 0x3F800000, 0xC0 gives 0xBF800000, 0x44 gives 0x40000000). For every code except 0x80, output bit 31 equals input bit 7.
- R2: A code with E = 0 and F ≠ 0 is subnormal with value (-1)^sign × F × 2^-17, emitted as a normal single (0x01 gives 0x37000000, 0x02 gives 0x37800000, 0x03 gives 0x37C00000).
- R3: Code 0x00 gives +0.0 (0x00000000).
- R4: Codes 0x7E and 0xFE are the largest finite magnitudes, ±49152 (0x47400000 and 0xC7400000).
- R5: Code 0x7F gives +infinity (0x7F800000) and code 0xFF gives -infinity (0xFF800000).
- R6: Code 0x80 is the only not-a-number code and gives the quiet NaN 0x7FC00000.
- R7: out_vld equals the in_vld of the previous cycle, and out_word carries the result for the code presented in that cycle.
- R8: While in_vld is low, out_word keeps its value whatever in_code does.
- R9: A synchronous reset, taking priority over in_vld, clears out_vld and out_word to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Input code is valid this cycle |
| in_code | input | 8 | Narrow floating-point code |
| out_vld | output | 1 | Registered valid, one cycle after in_vld |
| out_word | output | 32 | Single-precision result |

## Verification
The subnormal codes are the hardest case. They are the only codes where the exponent depends on where the leading one sits in the fraction, and 0x03 is the only one that also leaves a fraction bit behind. The bench applies every one of the 256 codes back to back and compares each result with a reference. That reference builds the value as an integer significand times a power of two and normalises it separately, so positive and negative subnormals are both checked against exact expected words. Hold and reset are reached by dropping in_vld while in_code keeps changing, and by raising reset while a valid code is presented.

// File: rtl/f8w_pkg.sv
package f8w_pkg;

   typedef enum logic [2:0] {
      CLS_ZERO,
      CLS_SUB,
      CLS_NORM,
      CLS_INF,
      CLS_NAN
   } f8w_cls_e;

   localparam int SGL_EW   = 8;
   localparam int SGL_MW   = 23;
   localparam int SGL_W    = 1 + SGL_EW + SGL_MW;
   localparam int SGL_BIAS = 127;
   localparam int SGL_EMAX = 254;

   localparam logic [SGL_W-1:0] SGL_QNAN = 32'h7FC0_0000;

endpackage

// File: rtl/f8w_classify.sv
module f8w_classify
   import f8w_pkg::*;
#(
   parameter int EXP_W = 5,
   parameter int MAN_W = 2,
   localparam int IN_W = 1 + EXP_W + MAN_W
) (
   input  logic [IN_W-1:0]  code,
   output logic             sign,
   output logic [EXP_W-1:0] exp_f,
   output logic [MAN_W-1:0] man_f,
   output f8w_cls_e         cls
);

   logic [IN_W-2:0] mag;

   assign sign  = code[IN_W-1];
   assign mag   = code[IN_W-2:0];
   assign exp_f = code[IN_W-2 -: EXP_W];
   assign man_f = code[MAN_W-1:0];

   always_comb begin
      if (mag == '0) begin
         cls = sign ? CLS_NAN : CLS_ZERO;
      end else if (&mag) begin
         cls = CLS_INF;
      end else if (exp_f == '0) begin
         cls = CLS_SUB;
      end else begin
         cls = CLS_NORM;
      end
   end

endmodule

// File: rtl/f8w_lzc.sv
module f8w_lzc #(
   parameter int MAN_W = 2,
   localparam int LZ_W = $clog2(MAN_W) + 1
) (
   input  logic [MAN_W-1:0] man,
   output logic [LZ_W-1:0]  lz,
   output logic [MAN_W-1:0] frac
);

   generate
      if (MAN_W == 1) begin : g_single
         assign lz   = '0;
         assign frac = '0;
      end else begin : g_scan
         logic             found;
         logic [MAN_W-1:0] shifted;
         always_comb begin
            lz    = '0;
            found = 1'b0;
            for (int i = MAN_W - 1; i >= 0; i--) begin
               if (!found) begin
                  if (man[i]) begin
                     found = 1'b1;
                  end else begin
                     lz = lz + LZ_W'(1);
                  end
               end
            end
            shifted = man << lz;
            frac    = shifted << 1;
         end
      end
   endgenerate

endmodule

// File: rtl/f8w_pack.sv
module f8w_pack
   import f8w_pkg::*;
#(
   parameter int MAN_W = 2
) (
   input  logic              sign,
   input  f8w_cls_e          cls,
   input  logic [SGL_EW-1:0] exp_o,
   input  logic [MAN_W-1:0]  frac,
   output logic [SGL_W-1:0]  word
);

   always_comb begin
      case (cls)
         CLS_ZERO: word = '0;
         CLS_NAN:  word = SGL_QNAN;
         CLS_INF:  word = {sign, {SGL_EW{1'b1}}, {SGL_MW{1'b0}}};
         default:  word = {sign, exp_o, frac, {(SGL_MW-MAN_W){1'b0}}};
      endcase
   end

endmodule

// File: rtl/f8_widen.sv
module f8_widen
   import f8w_pkg::*;
#(
   parameter int EXP_W = 5,
   parameter int MAN_W = 2,
   parameter int BIAS  = 16,
   localparam int IN_W = 1 + EXP_W + MAN_W
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_vld,
   input  logic [IN_W-1:0]  in_code,
   output logic             out_vld,
   output logic [SGL_W-1:0] out_word
);

   localparam int LZ_W     = $clog2(MAN_W) + 1;
   localparam int OFS      = SGL_BIAS - BIAS;
   localparam int EXP_HIGH = (2 ** EXP_W - 1) + OFS;
   localparam int EXP_LOW  = OFS - (MAN_W - 1);

   if (EXP_W < 2) begin : g_bad_exp
      $error("f8_widen: EXP_W must be at least 2");
   end
   if (MAN_W < 1 || MAN_W >= SGL_MW) begin : g_bad_man
      $error("f8_widen: MAN_W out of range");
   end
   if (EXP_HIGH > SGL_EMAX || EXP_LOW < 1) begin : g_bad_range
      $error("f8_widen: exponent range does not fit single precision");
   end

   logic              sign;
   logic [EXP_W-1:0]  exp_f;
   logic [MAN_W-1:0]  man_f;
   f8w_cls_e          cls;
   logic [LZ_W-1:0]   lz;
   logic [MAN_W-1:0]  nfrac;
   logic [SGL_EW-1:0] exp_o;
   logic [MAN_W-1:0]  frac_o;
   logic [SGL_W-1:0]  word_nxt;

   f8w_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_classify (
      .code  (in_code),
      .sign  (sign),
      .exp_f (exp_f),
      .man_f (man_f),
      .cls   (cls)
   );

   f8w_lzc #(.MAN_W(MAN_W)) u_lzc (
      .man  (man_f),
      .lz   (lz),
      .frac (nfrac)
   );

   always_comb begin
      if (cls == CLS_SUB) begin
         exp_o  = SGL_EW'(OFS) - SGL_EW'(lz);
         frac_o = nfrac;
      end else begin
         exp_o  = SGL_EW'(exp_f) + SGL_EW'(OFS);
         frac_o = man_f;
      end
   end

   f8w_pack #(.MAN_W(MAN_W)) u_pack (
      .sign  (sign),
      .cls   (cls),
      .exp_o (exp_o),
      .frac  (frac_o),
      .word  (word_nxt)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_vld  <= 1'b0;
         out_word <= '0;
      end else begin
         out_vld <= in_vld;
         if (in_vld) begin
            out_word <= word_nxt;
         end
      end
   end

endmodule

// File: rtl/f8w_chk.sv
module f8w_chk #(
   parameter int EXP_W = 5,
   parameter int MAN_W = 2,
   localparam int IN_W = 1 + EXP_W + MAN_W
) (
   input logic            clk,
   input logic            rst,
   input logic            in_vld,
   input logic [IN_W-1:0] in_code,
   input logic            out_vld,
   input logic [31:0]     out_word
);

   localparam logic [IN_W-1:0] NAN_CODE = {1'b1, {(IN_W-1){1'b0}}};

   // R7
   vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
      in_vld |=> out_vld);

   // R7
   vld_drop_chk: assert property (@(posedge clk) disable iff (rst)
      !in_vld |=> !out_vld);

   // R8
   hold_word_chk: assert property (@(posedge clk) disable iff (rst)
      !in_vld |=> $stable(out_word));

   // R6
   nan_out_chk: assert property (@(posedge clk) disable iff (rst)
      (in_vld && in_code == NAN_CODE) |=> out_word == 32'h7FC0_0000);

   // R5
   inf_out_chk: assert property (@(posedge clk) disable iff (rst)
      (in_vld && (&in_code[IN_W-2:0]))
      |=> (out_word[30:0] == 31'h7F80_0000 && out_word[31] == $past(in_code[IN_W-1])));

   // R3
   zero_out_chk: assert property (@(posedge clk) disable iff (rst)
      (in_vld && in_code == '0) |=> out_word == 32'h0);

   // R1
   sign_keep_chk: assert property (@(posedge clk) disable iff (rst)
      (in_vld && in_code != NAN_CODE) |=> out_word[31] == $past(in_code[IN_W-1]));

   // R9
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (!out_vld && out_word == 32'h0));

endmodule

bind f8_widen f8w_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .in_vld   (in_vld),
   .in_code  (in_code),
   .out_vld  (out_vld),
   .out_word (out_word)
);

// File: tb/f8_widen_bench.sv
module f8_widen_bench;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_vld = 1'b0;
   logic [7:0]  in_code = 8'h00;
   logic        out_vld;
   logic [31:0] out_word;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   f8_widen u_f8_widen (
      .clk      (clk),
      .rst      (rst),
      .in_vld   (in_vld),
      .in_code  (in_code),
      .out_vld  (out_vld),
      .out_word (out_word)
   );

   function automatic logic [31:0] ref_conv(input logic [7:0] c);
      int e, f, m, k, p, ex, fr;
      e = int'(c[6:2]);
      f = int'(c[1:0]);
      if (c == 8'h80) return 32'h7FC0_0000;
      if (c[6:0] == 7'h7F) return {c[7], 31'h7F80_0000};
      if (c[6:0] == 7'h00) return 32'h0;
      if (e == 0) begin
         m = f;
         k = -17;
      end else begin
         m = 4 + f;
         k = e - 18;
      end
      p  = (m >= 4) ? 2 : ((m >= 2) ? 1 : 0);
      ex = k + p + 127;
      fr = (m - (1 << p)) << (23 - p);
      return {c[7], ex[7:0], fr[22:0]};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic apply(input logic [7:0] c);
      in_vld  = 1'b1;
      in_code = c;
      @(negedge clk);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R9 reset vld", {31'b0, out_vld}, 32'h0);
      chk("R9 reset word", out_word, 32'h0);
      rst = 1'b0;
   endtask

   task automatic t_named();
      apply(8'h40); chk("R1 +1.0", out_word, 32'h3F80_0000);
      chk("R7 vld after valid", {31'b0, out_vld}, 32'h1);
      apply(8'hC0); chk("R1 -1.0", out_word, 32'hBF80_0000);
      apply(8'h44); chk("R1 +2.0", out_word, 32'h4000_0000);
      apply(8'h01); chk("R2 min sub", out_word, 32'h3700_0000);
      apply(8'h02); chk("R2 sub 2", out_word, 32'h3780_0000);
      apply(8'h03); chk("R2 sub 3", out_word, 32'h37C0_0000);
      apply(8'h83); chk("R2 neg sub", out_word, 32'hB7C0_0000);
      apply(8'h00); chk("R3 zero", out_word, 32'h0);
      apply(8'h7E); chk("R4 max", out_word, 32'h4740_0000);
      apply(8'hFE); chk("R4 -max", out_word, 32'hC740_0000);
      apply(8'h7F); chk("R5 +inf", out_word, 32'h7F80_0000);
      apply(8'hFF); chk("R5 -inf", out_word, 32'hFF80_0000);
      apply(8'h80); chk("R6 nan", out_word, 32'h7FC0_0000);
   endtask

   task automatic t_sweep();
      for (int i = 0; i < 256; i++) begin
         apply(8'(i));
         chk("R7 sweep vld", {31'b0, out_vld}, 32'h1);
         chk("R1 sweep word", out_word, ref_conv(8'(i)));
      end
   endtask

   task automatic t_hold();
      apply(8'h44);
      in_vld = 1'b0;
      for (int i = 0; i < 3; i++) begin
         in_code = (i == 0) ? 8'h7F : ((i == 1) ? 8'h80 : 8'h01);
         @(negedge clk);
         chk("R8 hold word", out_word, 32'h4000_0000);
         chk("R7 vld low", {31'b0, out_vld}, 32'h0);
      end
      apply(8'hC0); chk("R7 resume", out_word, 32'hBF80_0000);
   endtask

   task automatic t_mid_reset();
      in_vld  = 1'b1;
      in_code = 8'h40;
      rst     = 1'b1;
      @(negedge clk);
      chk("R9 mid reset vld", {31'b0, out_vld}, 32'h0);
      chk("R9 mid reset word", out_word, 32'h0);
      rst = 1'b0;
      apply(8'hFE); chk("R9 after reset", out_word, 32'hC740_0000);
      in_vld = 1'b0;
   endtask

   initial begin
      t_reset();
      t_named();
      t_sweep();
      t_hold();
      t_mid_reset();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule